// File: doc/BRIEF.md
# CRC Peripheral Register Bank

This block is the software-facing register bank of a CRC peripheral. A simple word-addressed bus (address, write enable, read enable, write data, read data) reaches a small set of 32-bit registers. These registers hold a descriptor base pointer, a DMA channel enable, two interrupt sources with their masks, the engine mode, the latest CRC result and a fixed version word. The block does not compute CRCs or fetch memory. It hands the mode fields, the descriptor pointer, the channel enable and a one-cycle reset strobe to those neighbours. In return it takes a transfer-complete pulse, a compare-mismatch pulse and result updates from them.

Every enable, mask and status bit uses the same convention. Software writes a 1 to bit 0 of one register to set the bit and writes a 1 to bit 0 of a partner register to clear it. A separate read-only register reports the current value. The two status bits are sticky and are cleared when software reads them. A single interrupt line combines the masked status bits. While compare mode is on, the result register reads as zero.

Top module: `crc_regblock`

## Requirements
- R1: After reset, every stored bit is zero: `dma_en_o`, `irq_o`, `crc_reset_o`, the mode outputs, `desc_base_o` and `bus_rdata` are all 0.
- R2: A write to offset 0x00 stores bits 31:9 of the write data as the descriptor base. Reads of 0x00 and `desc_base_o` show bits 8:0 as zero.
- R3: Three set/clear pairs each feed a read-only view at bit 0: DMA channel (set 0x08, clear 0x0C, view 0x10), DMA interrupt mask (set 0x14, clear 0x18, view 0x1C) and error interrupt mask (set 0x40, clear 0x44, view 0x48). A write with bit 0 = 1 sets or clears the bit. A write with bit 0 = 0 leaves it unchanged. `dma_en_o` follows the DMA channel bit.
- R4: A `dma_done_i` pulse sets the transfer-complete status, which is bit 0 of offset 0x20. A read of 0x20 returns the value before the clear and then clears the bit. If `dma_done_i` arrives in the same cycle as that read, the bit stays set.
- R5: A `cmp_err_i` pulse sets the compare-error status, which is bit 0 of offset 0x4C. A read of 0x4C returns the bit and then clears it, with the same rule as R4 when an event coincides with the read.
- R6: `irq_o` is high exactly when (transfer-complete status AND DMA interrupt mask) OR (compare-error status AND error interrupt mask). It changes in the cycle after the edge that changed the state.
- R7: The mode register at offset 0x38 keeps write data bits 7:0: enable at bit 0, compare at bit 1, polynomial select at bits 3:2 and bandwidth divider at bits 7:4. These fields drive the mode outputs. Bits 31:8 read as zero.
- R8: A write of bit 0 = 1 to the control register at offset 0x34 raises `crc_reset_o` for exactly one cycle after the write edge and clears the stored result to zero. A write with bit 0 = 0 does nothing.
- R9: When `crc_load_i` is high, the stored result takes `crc_value_i`. If a control reset happens in the same cycle, the reset takes priority and the result becomes zero.
- R10: A read of the result register at offset 0x3C returns the stored result while the compare bit is 0 and returns zero while it is 1. The stored value is not lost.
- R11: Offset 0xFC reads 0x00000202.
- R12: Read data appears on `bus_rdata` in the cycle after `bus_ren` and is zero in every other cycle. Reads of unmapped offsets and of write-only registers return zero. Writes to unmapped offsets and to read-only registers change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (8) | Byte address; bits 1:0 ignored |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_ren` |
| dma_done_i | input | 1 | Transfer-complete event pulse |
| cmp_err_i | input | 1 | Compare-mismatch event pulse |
| crc_load_i | input | 1 | Result update strobe from the engine |
| crc_value_i | input | 32 | Result value from the engine |
| irq_o | output | 1 | Combined masked interrupt |
| dma_en_o | output | 1 | Descriptor fetcher channel enable |
| desc_base_o | output | 32 | Descriptor base address, low 9 bits zero |
| crc_reset_o | output | 1 | One-cycle intermediate-result reset strobe |
| mode_en_o | output | 1 | Engine enable |
| mode_cmp_o | output | 1 | Compare mode |
| mode_poly_o | output | 2 | Polynomial select |
| mode_div_o | output | 4 | Bandwidth divider |

## Verification
The hardest case to reach from the ports is a status event that arrives in the very cycle a read clears that status. The event must survive the clear, and the read must still return the value from before the clear. The bench drives `dma_done_i` together with the read strobe on 0x20 and then reads twice more: the first of these reads must return 1 and the second must return 0. A second hard case is a result update that coincides with a control reset. The bench drives `crc_load_i` in the same cycle as the control write and then reads the result back, expecting zero.

// File: rtl/crc_reg_pkg.sv
package crc_reg_pkg;

    localparam int DATA_W     = 32;
    localparam int NREG       = 16;
    localparam int ALIGN_BITS = 9;
    localparam logic [11:0] VERSION_ID = 12'h202;

    // Register identifiers; each maps to one word offset below.
    typedef enum logic [3:0] {
        RID_DESC    = 4'd0,
        RID_CH_SET  = 4'd1,
        RID_CH_CLR  = 4'd2,
        RID_CH_VIEW = 4'd3,
        RID_DM_SET  = 4'd4,
        RID_DM_CLR  = 4'd5,
        RID_DM_VIEW = 4'd6,
        RID_DSTAT   = 4'd7,
        RID_CTRL    = 4'd8,
        RID_MODE    = 4'd9,
        RID_RESULT  = 4'd10,
        RID_EM_SET  = 4'd11,
        RID_EM_CLR  = 4'd12,
        RID_EM_VIEW = 4'd13,
        RID_ESTAT   = 4'd14,
        RID_VER     = 4'd15
    } rid_e;

    // Indices into the set/clear bank and the sticky bank.
    localparam int SC_CHAN  = 0;
    localparam int SC_DMSK  = 1;
    localparam int SC_EMSK  = 2;
    localparam int NSC      = 3;
    localparam int ST_DONE  = 0;
    localparam int ST_ERR   = 1;
    localparam int NST      = 2;

    typedef struct packed {
        logic [3:0] div;
        logic [1:0] poly;
        logic       cmp;
        logic       en;
    } mode_t;

    function automatic logic [7:0] rid_offset(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h08;
            2:       return 8'h0C;
            3:       return 8'h10;
            4:       return 8'h14;
            5:       return 8'h18;
            6:       return 8'h1C;
            7:       return 8'h20;
            8:       return 8'h34;
            9:       return 8'h38;
            10:      return 8'h3C;
            11:      return 8'h40;
            12:      return 8'h44;
            13:      return 8'h48;
            14:      return 8'h4C;
            default: return 8'hFC;
        endcase
    endfunction

endpackage

// File: rtl/crc_addr_decode.sv
module crc_addr_decode
    import crc_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    input  logic              ren,
    output logic [NREG-1:0]   wr_hit,
    output logic [NREG-1:0]   rd_hit
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [NREG-1:0] match;
    logic            unused_lsb;

    assign unused_lsb = ^addr[1:0];

    for (genvar g = 0; g < NREG; g++) begin : g_match
        localparam logic [7:0] OFS = rid_offset(g);
        assign match[g]  = (addr[ADDR_W-1:2] == WIDX_W'(OFS >> 2));
        assign wr_hit[g] = wen & match[g];
        assign rd_hit[g] = ren & match[g];
    end

endmodule

// File: rtl/crc_setclr_bank.sv
module crc_setclr_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] bits_o
);
    logic [N-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        for (int i = 0; i < N; i++) begin
            if (set_i[i]) bits_d[i] = 1'b1;
            if (clr_i[i]) bits_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign bits_o = bits_q;

endmodule

// File: rtl/crc_sticky_bank.sv
module crc_sticky_bank #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] event_i,
    input  logic [N-1:0] rdclr_i,
    output logic [N-1:0] stat_o
);
    logic [N-1:0] stat_d, stat_q;

    // A new event outranks a read-clear in the same cycle.
    always_comb begin
        stat_d = (stat_q & ~rdclr_i) | event_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/crc_regblock.sv
module crc_regblock
    import crc_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic              bus_ren,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dma_done_i,
    input  logic              cmp_err_i,
    input  logic              crc_load_i,
    input  logic [31:0]       crc_value_i,
    output logic              irq_o,
    output logic              dma_en_o,
    output logic [31:0]       desc_base_o,
    output logic              crc_reset_o,
    output logic              mode_en_o,
    output logic              mode_cmp_o,
    output logic [1:0]        mode_poly_o,
    output logic [3:0]        mode_div_o
);
    localparam int BASE_W = DATA_W - ALIGN_BITS;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        mode_t             mode;
        logic [DATA_W-1:0] result;
        logic              rst_pulse;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t s_d, s_q;

    logic [NREG-1:0]   wr_hit, rd_hit;
    logic [NSC-1:0]    sc_set, sc_clr, sc_bits;
    logic [NST-1:0]    st_ev, st_clr, st_bits;
    logic [DATA_W-1:0] rd_view [NREG];
    logic [DATA_W-1:0] rd_val;
    logic              ctrl_fire;
    logic              unused_sig;

    crc_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
        .addr   (bus_addr),
        .wen    (bus_wen),
        .ren    (bus_ren),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    assign sc_set[SC_CHAN] = wr_hit[RID_CH_SET] & bus_wdata[0];
    assign sc_clr[SC_CHAN] = wr_hit[RID_CH_CLR] & bus_wdata[0];
    assign sc_set[SC_DMSK] = wr_hit[RID_DM_SET] & bus_wdata[0];
    assign sc_clr[SC_DMSK] = wr_hit[RID_DM_CLR] & bus_wdata[0];
    assign sc_set[SC_EMSK] = wr_hit[RID_EM_SET] & bus_wdata[0];
    assign sc_clr[SC_EMSK] = wr_hit[RID_EM_CLR] & bus_wdata[0];

    crc_setclr_bank #(.N(NSC)) sc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (sc_set),
        .clr_i  (sc_clr),
        .bits_o (sc_bits)
    );

    assign st_ev[ST_DONE]  = dma_done_i;
    assign st_ev[ST_ERR]   = cmp_err_i;
    assign st_clr[ST_DONE] = rd_hit[RID_DSTAT];
    assign st_clr[ST_ERR]  = rd_hit[RID_ESTAT];

    crc_sticky_bank #(.N(NST)) st_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .event_i (st_ev),
        .rdclr_i (st_clr),
        .stat_o  (st_bits)
    );

    assign ctrl_fire = wr_hit[RID_CTRL] & bus_wdata[0];

    // Per-register read views; write-only slots stay zero.
    always_comb begin
        for (int i = 0; i < NREG; i++) rd_view[i] = '0;
        rd_view[RID_DESC]    = {s_q.base, {ALIGN_BITS{1'b0}}};
        rd_view[RID_CH_VIEW] = {{(DATA_W-1){1'b0}}, sc_bits[SC_CHAN]};
        rd_view[RID_DM_VIEW] = {{(DATA_W-1){1'b0}}, sc_bits[SC_DMSK]};
        rd_view[RID_DSTAT]   = {{(DATA_W-1){1'b0}}, st_bits[ST_DONE]};
        rd_view[RID_MODE]    = {{(DATA_W-8){1'b0}}, s_q.mode};
        rd_view[RID_RESULT]  = s_q.mode.cmp ? '0 : s_q.result;
        rd_view[RID_EM_VIEW] = {{(DATA_W-1){1'b0}}, sc_bits[SC_EMSK]};
        rd_view[RID_ESTAT]   = {{(DATA_W-1){1'b0}}, st_bits[ST_ERR]};
        rd_view[RID_VER]     = {{(DATA_W-12){1'b0}}, VERSION_ID};
    end

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NREG; i++) begin
            if (rd_hit[i]) rd_val = rd_val | rd_view[i];
        end
    end

    always_comb begin
        s_d = s_q;
        if (wr_hit[RID_DESC]) s_d.base = bus_wdata[DATA_W-1:ALIGN_BITS];
        if (wr_hit[RID_MODE]) s_d.mode = mode_t'(bus_wdata[7:0]);
        if (crc_load_i)       s_d.result = crc_value_i;
        if (ctrl_fire)        s_d.result = '0;
        s_d.rst_pulse = ctrl_fire;
        s_d.rdata     = bus_ren ? rd_val : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata   = s_q.rdata;
    assign desc_base_o = {s_q.base, {ALIGN_BITS{1'b0}}};
    assign crc_reset_o = s_q.rst_pulse;
    assign dma_en_o    = sc_bits[SC_CHAN];
    assign mode_en_o   = s_q.mode.en;
    assign mode_cmp_o  = s_q.mode.cmp;
    assign mode_poly_o = s_q.mode.poly;
    assign mode_div_o  = s_q.mode.div;
    assign irq_o       = (st_bits[ST_DONE] & sc_bits[SC_DMSK])
                       | (st_bits[ST_ERR]  & sc_bits[SC_EMSK]);

    assign unused_sig = ^{bus_wdata[8], wr_hit[RID_CH_VIEW], wr_hit[RID_DM_VIEW],
                          wr_hit[RID_DSTAT], wr_hit[RID_RESULT], wr_hit[RID_EM_VIEW],
                          wr_hit[RID_ESTAT], wr_hit[RID_VER], rd_hit[RID_CH_SET]};

endmodule

module crc_regblock_chk
    import crc_reg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wen,
    input logic              bus_ren,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              dma_done_i,
    input logic              cmp_err_i,
    input logic              irq_o,
    input logic              dma_en_o,
    input logic [31:0]       desc_base_o,
    input logic              crc_reset_o,
    input logic              mode_cmp_o
);
    logic wa;
    assign wa = (bus_addr[1:0] == 2'b00);

    assert_desc_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && wa && bus_addr == ADDR_W'(8'h00))
        |=> (desc_base_o == {$past(bus_wdata[31:9]), 9'b0}));

    assert_chan_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && wa && bus_addr == ADDR_W'(8'h08) && bus_wdata[0]) |=> dma_en_o);

    assert_chan_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && wa && bus_addr == ADDR_W'(8'h0C) && bus_wdata[0]) |=> !dma_en_o);

    assert_chan_zero_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && !bus_wdata[0]) |=> $stable(dma_en_o));

    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(dma_done_i || cmp_err_i || (bus_wen && bus_wdata[0])));

    assert_ctrl_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && wa && bus_addr == ADDR_W'(8'h34) && bus_wdata[0]) |=> crc_reset_o);

    assert_ctrl_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wen && bus_addr == ADDR_W'(8'h34)) |=> !crc_reset_o);

    assert_result_hidden_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ren && wa && bus_addr == ADDR_W'(8'h3C) && mode_cmp_o) |=> (bus_rdata == 32'h0));

    assert_version_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ren && wa && bus_addr == ADDR_W'(8'hFC)) |=> (bus_rdata == 32'h202));

    assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ren |=> (bus_rdata == 32'h0));

endmodule

bind crc_regblock crc_regblock_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wen     (bus_wen),
    .bus_ren     (bus_ren),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .dma_done_i  (dma_done_i),
    .cmp_err_i   (cmp_err_i),
    .irq_o       (irq_o),
    .dma_en_o    (dma_en_o),
    .desc_base_o (desc_base_o),
    .crc_reset_o (crc_reset_o),
    .mode_cmp_o  (mode_cmp_o)
);

// File: tb/crc_regblock_tb_top.sv
module crc_regblock_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic        bus_ren = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        dma_done_i = 1'b0;
    logic        cmp_err_i = 1'b0;
    logic        crc_load_i = 1'b0;
    logic [31:0] crc_value_i = '0;
    logic        irq_o, dma_en_o, crc_reset_o, mode_en_o, mode_cmp_o;
    logic [31:0] desc_base_o;
    logic [1:0]  mode_poly_o;
    logic [3:0]  mode_div_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        ren_seen = 1'b0;

    always #4 clk = ~clk;

    crc_regblock dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_ren(bus_ren), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_done_i(dma_done_i), .cmp_err_i(cmp_err_i), .crc_load_i(crc_load_i),
        .crc_value_i(crc_value_i), .irq_o(irq_o), .dma_en_o(dma_en_o),
        .desc_base_o(desc_base_o), .crc_reset_o(crc_reset_o), .mode_en_o(mode_en_o),
        .mode_cmp_o(mode_cmp_o), .mode_poly_o(mode_poly_o), .mode_div_o(mode_div_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected item per completed read.
    always @(posedge clk) ren_seen <= bus_ren;
    always @(negedge clk) begin
        if (ren_seen && exp_q.size() > 0) begin
            check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = a; bus_ren = 1'b1;
        exp_q.push_back(e); tag_q.push_back(req);
        @(negedge clk);
        bus_ren = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); dma_done_i = 1'b1;
        @(negedge clk); dma_done_i = 1'b0;
    endtask

    task automatic pulse_err();
        @(negedge clk); cmp_err_i = 1'b1;
        @(negedge clk); cmp_err_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check({irq_o, dma_en_o, crc_reset_o, mode_en_o, mode_cmp_o, mode_poly_o, mode_div_o},
              '0, "R1 outputs");
        check(desc_base_o, 32'h0, "R1 desc");
        check(bus_rdata, 32'h0, "R1 rdata");
        rd(8'h38, 32'h0, "R1 mode");
        rd(8'h10, 32'h0, "R1 chan");
        // R11
        rd(8'hFC, 32'h0000_0202, "R11 version");
        // R2
        wr(8'h00, 32'hFFFF_FFFF);
        check(desc_base_o, 32'hFFFF_FE00, "R2 desc out");
        rd(8'h00, 32'hFFFF_FE00, "R2 desc read");
        wr(8'h00, 32'h1234_5A5A);
        rd(8'h00, 32'h1234_5A00, "R2 desc read2");
        // R3 channel pair
        wr(8'h08, 32'h0000_0001);
        check(dma_en_o, 1, "R3 chan set");
        wr(8'h0C, 32'hFFFF_FFFE);
        check(dma_en_o, 1, "R3 clear zero noop");
        rd(8'h10, 32'h1, "R3 chan view");
        wr(8'h0C, 32'h1);
        check(dma_en_o, 0, "R3 chan clear");
        rd(8'h10, 32'h0, "R3 chan view2");
        wr(8'h08, 32'h0);
        check(dma_en_o, 0, "R3 set zero noop");
        // R4 / R6 transfer-complete
        pulse_done();
        check(irq_o, 0, "R6 masked off");
        wr(8'h14, 32'h1);
        check(irq_o, 1, "R6 dma irq");
        rd(8'h1C, 32'h1, "R3 dma mask view");
        rd(8'h20, 32'h1, "R4 status read");
        check(irq_o, 0, "R6 irq after clear");
        rd(8'h20, 32'h0, "R4 cleared");
        // R4 event coincides with read-clear
        pulse_done();
        @(negedge clk);
        bus_addr = 8'h20; bus_ren = 1'b1; dma_done_i = 1'b1;
        exp_q.push_back(32'h1); tag_q.push_back("R4 race read");
        @(negedge clk);
        bus_ren = 1'b0; dma_done_i = 1'b0;
        check(irq_o, 1, "R4 race keeps status");
        rd(8'h20, 32'h1, "R4 race survives");
        rd(8'h20, 32'h0, "R4 race then clear");
        wr(8'h18, 32'h1);
        rd(8'h1C, 32'h0, "R3 dma mask clear");
        // R5 / R6 compare error
        wr(8'h40, 32'h1);
        pulse_err();
        check(irq_o, 1, "R6 err irq");
        rd(8'h48, 32'h1, "R3 err mask view");
        rd(8'h4C, 32'h1, "R5 status read");
        check(irq_o, 0, "R5 irq after clear");
        rd(8'h4C, 32'h0, "R5 cleared");
        wr(8'h44, 32'h1);
        rd(8'h48, 32'h0, "R3 err mask clear");
        pulse_err();
        check(irq_o, 0, "R6 err masked");
        rd(8'h4C, 32'h1, "R5 set while masked");
        // R7 mode
        wr(8'h38, 32'hFFFF_FF6D);
        rd(8'h38, 32'h0000_006D, "R7 mode read");
        check({mode_div_o, mode_poly_o, mode_cmp_o, mode_en_o}, 32'h6D, "R7 fields");
        check(mode_poly_o, 2'd3, "R7 poly");
        // R9 / R10 result
        @(negedge clk); crc_value_i = 32'hDEAD_BEEF; crc_load_i = 1'b1;
        @(negedge clk); crc_load_i = 1'b0;
        rd(8'h3C, 32'hDEAD_BEEF, "R9 result load");
        wr(8'h38, 32'h0000_0002);
        check(mode_cmp_o, 1, "R7 compare bit");
        rd(8'h3C, 32'h0, "R10 hidden");
        wr(8'h38, 32'h0);
        rd(8'h3C, 32'hDEAD_BEEF, "R10 value kept");
        // R12 read-only write ignored
        wr(8'h3C, 32'h0000_FFFF);
        rd(8'h3C, 32'hDEAD_BEEF, "R12 ro write");
        wr(8'h10, 32'h1);
        check(dma_en_o, 0, "R12 view write");
        // R8 control
        wr(8'h34, 32'h0);
        check(crc_reset_o, 0, "R8 zero noop");
        rd(8'h3C, 32'hDEAD_BEEF, "R8 zero keeps");
        wr(8'h34, 32'h1);
        check(crc_reset_o, 1, "R8 pulse");
        @(negedge clk);
        check(crc_reset_o, 0, "R8 one cycle");
        rd(8'h3C, 32'h0, "R8 result cleared");
        // R9 reset wins over load
        @(negedge clk);
        bus_addr = 8'h34; bus_wdata = 32'h1; bus_wen = 1'b1;
        crc_value_i = 32'h1357_2468; crc_load_i = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0; crc_load_i = 1'b0;
        rd(8'h3C, 32'h0, "R9 reset priority");
        // R12 unmapped and write-only
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, 32'h0, "R12 unmapped");
        rd(8'h08, 32'h0, "R12 write-only");
        rd(8'h80, 32'h0, "R12 unmapped high");
        @(negedge clk);
        check(bus_rdata, 32'h0, "R12 idle zero");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check(exp_q.size(), 0, "R12 reads pending");
        finish_run();
    end

endmodule